// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a run of words between one I/O device port and main memory so that the processor does not have to copy each word. Software programs a command with four values: the direction, the device address, the first memory address and the word count. It then writes a start bit. From that point the engine works alone. For each word it asks for the system bus, makes exactly one memory access, and then gives the bus back. While it waits on the device it does not hold the bus, so the processor only loses the cycles that are actually spent moving words.

Words pass the device side through a valid/ready pair in each direction. A slow device, or a bus that grants late, simply stalls the engine and no word is lost. When the last word has moved, a sticky done flag is set and the interrupt line is raised. Both stay up until software clears them, or until software starts a new command. A command with a word count of zero completes at once and touches neither the bus nor the device.

Top module: `dma_engine`

## Requirements
- R1: After reset, `irq`, `bus_req`, `mem_we`, `dev_in_ready` and `dev_out_valid` are low, and the status word (select 0) reads zero.
- R2: The program port has four registers, chosen by `cfg_addr`:
  - Select 1 holds the device address (low 8 bits), which is driven on `dev_sel`.
  - Select 2 is written with the memory start address and reads back the engine's live memory address.
  - Select 3 is written with the word count and reads back the words still to move.
  - A write to select 0 is a control word: bit 0 is the direction (1 = memory to device, 0 = device to memory), bit 1 is start, and bit 2 clears done.
  - A read of select 0 returns bit 0 = busy and bit 1 = done.
  - After a transfer, select 2 reads start + count and select 3 reads 0.
- R3: In device-to-memory mode, the k-th word accepted on `dev_in_valid && dev_in_ready` is written to memory address start + k. No address outside start .. start+count-1 is written.
- R4: In memory-to-device mode, the word at start + k is the k-th word presented on `dev_out_data`. `dev_out_valid` and the data stay steady until `dev_out_ready`.
- R5: `bus_req` stays high until `bus_gnt` is seen. Exactly one memory access happens in the grant cycle. `bus_req` is low in the following cycle, and `mem_we` is high only while the bus is granted.
- R6: The bus is granted exactly count times per transfer, and `bus_req` is low while the engine waits for a device word.
- R7: Stalls on `bus_gnt`, `dev_in_valid` or `dev_out_ready` delay the transfer but lose, repeat or reorder no word.
- R8: In the cycle after the last word moves, busy falls, done is set and `irq` rises.
- R9: A start with a word count of zero sets done and `irq` in the next cycle, with no bus request and no device handshake.
- R10: Done and `irq` stay set until a control write with bit 2 set, or a new start. A control write without bit 2 leaves them set.
- R11: While busy, writes to any register, including a second start, are ignored. The running transfer ends with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Program-port write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Program-port write data |
| cfg_rdata | output | 16 | Program-port read data (combinational) |
| irq | output | 1 | Completion interrupt, mirrors done |
| dev_sel | output | 8 | Device address of the command |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the grant cycle |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_ready | output | 1 | Engine accepts a device word |
| dev_in_data | input | 16 | Word from device |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_out_data | output | 16 | Word to device |

## Verification
The bench runs transfers in both directions under several grant and device stall ratios. An engine that drops or repeats a word under stall, or that advances its address on a stalled cycle, would leave a shifted or gapped pattern in memory or in the captured device stream. It counts grants per transfer, which exposes a design that keeps the bus across words or requests it while the device is idle, and it checks that the word just past the block is untouched so an off-by-one ending cannot hide. It also covers three corner cases:
- A zero-length command: a design that decrements before testing would wrap the count and run away on the bus.
- A second start and register writes while busy: a design that accepted them would change the address or count part way through.
- A control write without the clear bit: a design with a non-sticky done flag would drop `irq`.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int unsigned DMA_DW   = 16;
    localparam int unsigned DMA_AW   = 16;
    localparam int unsigned DMA_CW   = 16;
    localparam int unsigned DMA_DEVW = 8;
    localparam int unsigned DMA_SELW = 2;

    localparam int unsigned CTL_DIR   = 0;
    localparam int unsigned CTL_START = 1;
    localparam int unsigned CTL_CLEAR = 2;
    localparam int unsigned STS_BUSY  = 0;
    localparam int unsigned STS_DONE  = 1;

    typedef enum logic [DMA_SELW-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DEV   = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DIR_TO_MEM = 1'b0,
        DIR_TO_DEV = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_DEV_IN,
        XS_BUS,
        XS_DEV_OUT
    } xfer_state_e;

    typedef struct packed {
        dir_e                dir;
        logic [DMA_DEVW-1:0] dev;
        logic [DMA_AW-1:0]   base;
        logic [DMA_CW-1:0]   count;
    } dma_cmd_t;

    function automatic logic is_last(input logic [DMA_CW-1:0] n);
        return n == DMA_CW'(1);
    endfunction

    function automatic logic [DMA_DW-1:0] status_word(input logic busy, input logic done);
        logic [DMA_DW-1:0] w;
        w           = '0;
        w[STS_BUSY] = busy;
        w[STS_DONE] = done;
        return w;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [DMA_SELW-1:0] cfg_addr,
    input  logic [DMA_DW-1:0]   cfg_wdata,
    output logic [DMA_DW-1:0]   cfg_rdata,
    input  logic                busy,
    input  logic                finish,
    input  logic [DMA_AW-1:0]   live_addr,
    input  logic [DMA_CW-1:0]   live_remain,
    output dma_cmd_t            cmd,
    output dma_cmd_t            launch,
    output logic                go,
    output logic                done
);

    reg_sel_e sel;
    dma_cmd_t cmd_q;
    logic     done_q;
    logic     prog_ok;
    logic     ctrl_wr;
    logic     start_req;
    logic     clear_req;
    logic     zero_start;

    assign sel        = reg_sel_e'(cfg_addr);
    assign prog_ok    = cfg_we && !busy;
    assign ctrl_wr    = cfg_we && (sel == SEL_CTRL);
    assign start_req  = ctrl_wr && !busy && cfg_wdata[CTL_START];
    assign clear_req  = ctrl_wr && cfg_wdata[CTL_CLEAR];
    assign zero_start = start_req && (cmd_q.count == '0);
    assign go         = start_req && (cmd_q.count != '0);

    always_comb begin
        launch     = cmd_q;
        launch.dir = dir_e'(cfg_wdata[CTL_DIR]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (prog_ok) begin
            unique case (sel)
                SEL_CTRL:  cmd_q.dir   <= dir_e'(cfg_wdata[CTL_DIR]);
                SEL_DEV:   cmd_q.dev   <= cfg_wdata[DMA_DEVW-1:0];
                SEL_ADDR:  cmd_q.base  <= DMA_AW'(cfg_wdata);
                SEL_COUNT: cmd_q.count <= DMA_CW'(cfg_wdata);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (finish || zero_start) begin
            done_q <= 1'b1;
        end else if (start_req || clear_req) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  cfg_rdata = status_word(busy, done_q);
            SEL_DEV:   cfg_rdata = DMA_DW'(cmd_q.dev);
            SEL_ADDR:  cfg_rdata = DMA_DW'(live_addr);
            SEL_COUNT: cfg_rdata = DMA_DW'(live_remain);
        endcase
    end

    assign cmd  = cmd_q;
    assign done = done_q;

    AST_ZERO_START_DONE: assert property (@(posedge clk) disable iff (rst)
        zero_start |=> (done_q && !busy));                                   // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_q && !start_req && !clear_req) |=> done_q);                    // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy);                                                   // R8
    AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        finish |=> done_q);                                                  // R8
    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we) |=> $stable(cmd_q));                                // R11

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  dma_cmd_t          launch,
    output logic              busy,
    output logic              finish,
    output logic [DMA_AW-1:0] live_addr,
    output logic [DMA_CW-1:0] live_remain,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [DMA_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [DMA_DW-1:0] mem_wdata,
    input  logic [DMA_DW-1:0] mem_rdata,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [DMA_DW-1:0] dev_in_data,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [DMA_DW-1:0] dev_out_data
);

    xfer_state_e       state;
    dir_e              dir_q;
    logic [DMA_AW-1:0] addr_q;
    logic [DMA_CW-1:0] remain_q;
    logic [DMA_DW-1:0] word_q;
    logic              bus_hit;
    logic              out_hit;

    assign bus_req       = (state == XS_BUS);
    assign dev_in_ready  = (state == XS_DEV_IN);
    assign dev_out_valid = (state == XS_DEV_OUT);
    assign bus_hit       = bus_req && bus_gnt;
    assign out_hit       = dev_out_valid && dev_out_ready;
    assign mem_we        = bus_hit && (dir_q == DIR_TO_MEM);
    assign mem_addr      = addr_q;
    assign mem_wdata     = word_q;
    assign dev_out_data  = word_q;
    assign busy          = (state != XS_IDLE);
    assign live_addr     = addr_q;
    assign live_remain   = remain_q;
    assign finish        = is_last(remain_q) &&
                           ((bus_hit && dir_q == DIR_TO_MEM) || out_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= XS_IDLE;
            dir_q    <= DIR_TO_MEM;
            addr_q   <= '0;
            remain_q <= '0;
            word_q   <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (go) begin
                        dir_q    <= launch.dir;
                        addr_q   <= launch.base;
                        remain_q <= launch.count;
                        state    <= (launch.dir == DIR_TO_DEV) ? XS_BUS : XS_DEV_IN;
                    end
                end
                XS_DEV_IN: begin
                    if (dev_in_valid) begin
                        word_q <= dev_in_data;
                        state  <= XS_BUS;
                    end
                end
                XS_BUS: begin
                    if (bus_gnt) begin
                        addr_q <= addr_q + DMA_AW'(1);
                        if (dir_q == DIR_TO_MEM) begin
                            remain_q <= remain_q - DMA_CW'(1);
                            state    <= is_last(remain_q) ? XS_IDLE : XS_DEV_IN;
                        end else begin
                            word_q <= mem_rdata;
                            state  <= XS_DEV_OUT;
                        end
                    end
                end
                XS_DEV_OUT: begin
                    if (dev_out_ready) begin
                        remain_q <= remain_q - DMA_CW'(1);
                        state    <= is_last(remain_q) ? XS_IDLE : XS_BUS;
                    end
                end
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req);                                  // R5
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt) |=> !bus_req);                                  // R5
    AST_WE_GRANTED: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> bus_gnt);                                                 // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt) |=> (mem_addr == $past(mem_addr) + DMA_AW'(1))); // R3
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (dev_out_valid && !dev_out_ready) |=>
        (dev_out_valid && $stable(dev_out_data)));                           // R4
    AST_NO_BUS_WHILE_DEV: assert property (@(posedge clk) disable iff (rst)
        dev_in_ready |-> !bus_req);                                          // R6

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [DMA_SELW-1:0] cfg_addr,
    input  logic [DMA_DW-1:0]   cfg_wdata,
    output logic [DMA_DW-1:0]   cfg_rdata,
    output logic                irq,
    output logic [DMA_DEVW-1:0] dev_sel,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic [DMA_AW-1:0]   mem_addr,
    output logic                mem_we,
    output logic [DMA_DW-1:0]   mem_wdata,
    input  logic [DMA_DW-1:0]   mem_rdata,
    input  logic                dev_in_valid,
    output logic                dev_in_ready,
    input  logic [DMA_DW-1:0]   dev_in_data,
    output logic                dev_out_valid,
    input  logic                dev_out_ready,
    output logic [DMA_DW-1:0]   dev_out_data
);

    dma_cmd_t          cmd;
    dma_cmd_t          launch;
    logic              go;
    logic              done;
    logic              busy;
    logic              finish;
    logic [DMA_AW-1:0] live_addr;
    logic [DMA_CW-1:0] live_remain;

    dma_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .busy        (busy),
        .finish      (finish),
        .live_addr   (live_addr),
        .live_remain (live_remain),
        .cmd         (cmd),
        .launch      (launch),
        .go          (go),
        .done        (done)
    );

    dma_xfer u_xfer (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .launch        (launch),
        .busy          (busy),
        .finish        (finish),
        .live_addr     (live_addr),
        .live_remain   (live_remain),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data)
    );

    assign irq     = done;
    assign dev_sel = cmd.dev;

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
    import dma_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        irq;
    logic [7:0]  dev_sel;
    logic        bus_req;
    logic        bus_gnt;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        dev_in_valid;
    logic        dev_in_ready;
    logic [15:0] dev_in_data;
    logic        dev_out_valid;
    logic        dev_out_ready;
    logic [15:0] dev_out_data;

    dma_engine u_dut (.*);

    // vector table: direction, device, start, count, grant divider, device divider
    localparam int NV = 6;
    localparam int VDIR [NV] = '{0, 1, 0, 1, 0, 1};
    localparam int VDEV [NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    localparam int VMEM [NV] = '{16'h010, 16'h040, 16'h080, 16'h0C0, 16'h100, 16'h140};
    localparam int VCNT [NV] = '{4, 5, 7, 6, 1, 3};
    localparam int VGD  [NV] = '{1, 1, 3, 2, 4, 5};
    localparam int VDD  [NV] = '{1, 1, 2, 3, 5, 4};

    logic [15:0] mem [0:511];
    logic [15:0] rec [0:63];
    int   src_idx, snk_idx, gnt_cnt, req_seen;
    int   n_words, gdiv, ddiv, cyc;
    logic [7:0] cur_dev;
    logic gnt_block, clr_req;
    int   total = 0, bad = 0;

    function automatic logic [15:0] init_val(input int a);
        return 16'hC300 ^ 16'(a);
    endfunction

    assign mem_rdata   = mem[mem_addr[8:0]];
    assign dev_in_data = {cur_dev, 8'(src_idx)};

    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
            src_idx <= 0; snk_idx <= 0; gnt_cnt <= 0; req_seen <= 0;
        end else begin
            if (mem_we && bus_gnt) mem[mem_addr[8:0]] <= mem_wdata;
            if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
            if (dev_out_valid && dev_out_ready) begin
                rec[snk_idx[5:0]] <= dev_out_data;
                snk_idx <= snk_idx + 1;
            end
            if (bus_req && bus_gnt) gnt_cnt <= gnt_cnt + 1;
            if (bus_req) req_seen <= req_seen + 1;
        end
    end

    always @(negedge clk) begin
        cyc           = cyc + 1;
        bus_gnt       = bus_req && !gnt_block && ((cyc % gdiv) == 0);
        dev_in_valid  = (src_idx < n_words) && ((cyc % ddiv) == 0);
        dev_out_ready = ((cyc % ddiv) == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        cfg_addr = 2'(a);
        #1 v = int'(cfg_rdata);
    endtask

    task automatic clear_env(input int nw, input int g, input int d, input int dev);
        @(negedge clk);
        clr_req = 1'b1; n_words = nw; gdiv = g; ddiv = d; cur_dev = 8'(dev);
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(irq == 1'b1, req, int'(irq), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
        gnt_block = 1'b0; clr_req = 1'b0; cyc = 0;
        n_words = 0; gdiv = 1; ddiv = 1; cur_dev = '0;
        src_idx = 0; snk_idx = 0; gnt_cnt = 0; req_seen = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
        chk(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
        chk(dev_in_ready == 1'b0 && dev_out_valid == 1'b0, "R1 device side",
            int'({dev_in_ready, dev_out_valid}), 0);
        rd(0, v);
        chk(v == 0, "R1 status", v, 0);

        // table-driven transfers, both directions, several stall ratios (R7)
        for (int t = 0; t < NV; t++) begin
            clear_env(VCNT[t], VGD[t], VDD[t], VDEV[t]);
            wr(1, VDEV[t]);
            wr(2, VMEM[t]);
            wr(3, VCNT[t]);
            wr(0, 2 | VDIR[t]);
            wait_irq("R8 irq after transfer");
            rd(0, v);
            chk(v == 2, "R8 status done not busy", v, 2);
            chk(dev_sel == 8'(VDEV[t]), "R2 dev_sel", int'(dev_sel), VDEV[t]);
            rd(2, v);
            chk(v == VMEM[t] + VCNT[t], "R2 live address", v, VMEM[t] + VCNT[t]);
            rd(3, v);
            chk(v == 0, "R2 remaining count", v, 0);
            chk(gnt_cnt == VCNT[t], "R6 grants per transfer", gnt_cnt, VCNT[t]);
            if (VDIR[t] == 0) begin
                for (int k = 0; k < VCNT[t]; k++)
                    chk(mem[VMEM[t] + k] == {8'(VDEV[t]), 8'(k)}, "R3 R7 memory word",
                        int'(mem[VMEM[t] + k]), int'({8'(VDEV[t]), 8'(k)}));
                chk(mem[VMEM[t] + VCNT[t]] == init_val(VMEM[t] + VCNT[t]), "R3 word past end",
                    int'(mem[VMEM[t] + VCNT[t]]), int'(init_val(VMEM[t] + VCNT[t])));
            end else begin
                chk(snk_idx == VCNT[t], "R4 words delivered", snk_idx, VCNT[t]);
                for (int k = 0; k < VCNT[t]; k++)
                    chk(rec[k] == init_val(VMEM[t] + k), "R4 R7 device word",
                        int'(rec[k]), int'(init_val(VMEM[t] + k)));
            end
            wr(0, 4);
            chk(irq == 1'b0, "R10 clear drops irq", int'(irq), 0);
        end

        // R11: writes and second start while busy are ignored
        clear_env(2, 1, 1, 8'h77);
        gnt_block = 1'b1;
        wr(1, 8'h77); wr(2, 16'h180); wr(3, 2); wr(0, 2);
        repeat (4) @(negedge clk);
        wr(2, 16'h1F0); wr(3, 9); wr(1, 8'h99); wr(0, 3);
        rd(0, v);
        chk(v == 1, "R11 busy while stalled", v, 1);
        rd(2, v);
        chk(v == 16'h180, "R11 address unchanged", v, 16'h180);
        rd(3, v);
        chk(v == 2, "R11 count unchanged", v, 2);
        chk(dev_sel == 8'h77, "R11 device unchanged", int'(dev_sel), 8'h77);
        gnt_block = 1'b0;
        wait_irq("R11 original transfer completes");
        chk(mem[16'h180] == 16'h7700 && mem[16'h181] == 16'h7701, "R11 data",
            int'(mem[16'h181]), 16'h7701);
        chk(gnt_cnt == 2 && snk_idx == 0, "R11 no second transfer", gnt_cnt, 2);
        wr(0, 4);

        // R9: zero-length command
        clear_env(0, 1, 1, 8'h77);
        wr(3, 0);
        wr(0, 2);
        chk(irq == 1'b1, "R9 zero count done at once", int'(irq), 1);
        rd(0, v);
        chk(v == 2, "R9 status", v, 2);
        chk(req_seen == 0, "R9 no bus request", req_seen, 0);

        // R10: sticky done
        repeat (20) @(negedge clk);
        chk(irq == 1'b1, "R10 irq held", int'(irq), 1);
        wr(0, 0);
        chk(irq == 1'b1, "R10 control write without clear", int'(irq), 1);
        wr(0, 4);
        chk(irq == 1'b0, "R10 clear", int'(irq), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule